// File: doc/BRIEF.md
# System Clock Ratio Detector

This block watches the frame-rate word-select signal of a serial audio port and works out how fast the system clock runs relative to it. It counts system clock cycles between successive rising edges of word-select and sorts the result into one of four legal ratios: 256, 384, 512 or 768 clocks per sample. The system clock and word-select are frequency-locked, so each period is a whole number of clocks. A small window around each nominal count absorbs edge jitter from the input synchroniser.

The result is a two-bit ratio code, a lock flag and an error flag. Lock is granted only when two consecutive measured periods fall in the same ratio window. A period that fits no window drops lock and raises the error flag, while the code keeps its last locked value. When the port is the frame master, only the 256 ratio is legal. The detector then stops measuring and reports the 256 code as locked.

Top module: `sysclk_ratio_det`

## Requirements
- R1: After reset in slave mode, `ratio_code` is 00, `locked` is 0 and `ratio_err` is 0.
- R2: The ratio code is encoded as 00 for 256, 01 for 384, 10 for 512 and 11 for 768 clocks per word-select period.
- R3: The first word-select rising edge after reset or after leaving master mode only starts a measurement. `locked` rises when two consecutive measured periods classify to the same ratio.
- R4: A period classifies to a ratio when it lies within ±2 clocks of the nominal count. A period 3 clocks away from every nominal matches none of them.
- R5: A period that matches no ratio clears `locked` and sets `ratio_err`. `ratio_code` keeps its previous value.
- R6: A matching period whose ratio differs from the previous matching period clears `locked` and leaves `ratio_err` and `ratio_code` unchanged. A following period of the same new ratio locks to the new code.
- R7: `ratio_err` stays set until lock is next granted, and it clears on that same update.
- R8: While `master_mode` is 1, the outputs are `ratio_code`=00, `locked`=1 and `ratio_err`=0, whatever word-select does. On return to slave mode, detection restarts from code 00, unlocked.
- R9: The outputs change only on the clock edge that comes two cycles after the edge that first samples word-select high. That is the third edge to see it high.
- R10: The period count saturates at 1023 with default parameters. A longer period, such as 1408 clocks, is a mismatch and is never aliased to a legal ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ws_in | input | 1 | Word-select from the serial port, asynchronous to sampling |
| master_mode | input | 1 | 1 = frame master (256 ratio forced), 0 = slave (detect) |
| ratio_code | output | 2 | Detected ratio: 00=256, 01=384, 10=512, 11=768 |
| locked | output | 1 | Two consecutive periods agreed on one ratio |
| ratio_err | output | 1 | Last classified period matched no ratio |

## Verification
The bench drives periods at both edges of each tolerance window (254, 766, 770) and just outside them (253, 259). A design with an off-by-one window would lock or flag the error in the wrong place. It switches from one legal ratio to another and checks that lock drops without an error; a design that carried the old candidate over would lock one period early. A 1408-clock period tests saturation, because a wrapping counter would alias it to 384 and stay locked. The bench also counts the exact edges between a late word-select rise and the error flag, and it checks that leaving master mode needs a fresh reference edge.

// File: rtl/sysclk_ratio_pkg.sv
package sysclk_ratio_pkg;

    // Detected ratio encoding (R2)
    typedef enum logic [1:0] {
        RATIO_256 = 2'b00,
        RATIO_384 = 2'b01,
        RATIO_512 = 2'b10,
        RATIO_768 = 2'b11
    } ratio_e;

    localparam int unsigned NUM_RATIOS = 4;

    // Result of classifying one measured period
    typedef struct packed {
        logic   hit;
        ratio_e ratio;
    } class_t;

    // Lock tracker state
    typedef struct packed {
        ratio_e code;
        ratio_e cand;
        logic   cand_ok;
        logic   locked;
        logic   err;
    } lock_st_t;

    // Nominal clocks per period for ratio index idx, as multiples of base
    function automatic int unsigned ratio_nominal(int unsigned base, int unsigned idx);
        case (idx)
            0:       return base * 2;
            1:       return base * 3;
            2:       return base * 4;
            default: return base * 6;
        endcase
    endfunction

    // Counter width large enough for the biggest nominal plus window
    function automatic int unsigned period_width(int unsigned base, int unsigned tol);
        return $clog2(ratio_nominal(base, NUM_RATIOS - 1) + tol + 2);
    endfunction

endpackage

// File: rtl/sr_ws_sync.sv
module sr_ws_sync (
    input  logic clk,
    input  logic rst,
    input  logic ws_i,
    output logic rise_o
);
    logic [2:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= 3'b000;
        end else begin
            sh_q <= {sh_q[1:0], ws_i};
        end
    end

    // Rising edge seen after two synchroniser stages
    assign rise_o = sh_q[1] & ~sh_q[2];
endmodule

// File: rtl/sr_period_cnt.sv
module sr_period_cnt #(
    parameter int unsigned CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             rise_i,
    output logic [CNT_W-1:0] period_o,
    output logic             event_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;
    logic             have_ref_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q      <= '0;
            have_ref_q <= 1'b0;
        end else if (rise_i) begin
            cnt_q      <= CNT_W'(1);
            have_ref_q <= 1'b1;
        end else if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign period_o = cnt_q;
    assign event_o  = rise_i & have_ref_q & ~clr;
endmodule

// File: rtl/sr_classify.sv
module sr_classify
    import sysclk_ratio_pkg::*;
#(
    parameter int unsigned BASE  = 128,
    parameter int unsigned TOL   = 2,
    parameter int unsigned CNT_W = 10
) (
    input  logic [CNT_W-1:0] period_i,
    output class_t           result_o
);
    logic [NUM_RATIOS-1:0] hit;

    for (genvar g = 0; g < NUM_RATIOS; g++) begin : g_win
        localparam int unsigned       NOM = ratio_nominal(BASE, g);
        localparam logic [CNT_W-1:0] LO  = CNT_W'(NOM - TOL);
        localparam logic [CNT_W-1:0] HI  = CNT_W'(NOM + TOL);
        assign hit[g] = (period_i >= LO) && (period_i <= HI);
    end

    always_comb begin
        result_o.hit   = |hit;
        result_o.ratio = RATIO_256;
        for (int i = 0; i < NUM_RATIOS; i++) begin
            if (hit[i]) result_o.ratio = ratio_e'(2'(i));
        end
    end
endmodule

// File: rtl/sr_lock_ctrl.sv
module sr_lock_ctrl
    import sysclk_ratio_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clr,
    input  logic     event_i,
    input  class_t   cls_i,
    output lock_st_t st_o
);
    localparam lock_st_t ST_IDLE = '{code: RATIO_256, cand: RATIO_256,
                                     cand_ok: 1'b0, locked: 1'b0, err: 1'b0};

    lock_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (event_i) begin
            if (!cls_i.hit) begin
                st_d.locked  = 1'b0;
                st_d.err     = 1'b1;
                st_d.cand_ok = 1'b0;
            end else if (st_q.cand_ok && (st_q.cand == cls_i.ratio)) begin
                st_d.locked = 1'b1;
                st_d.code   = cls_i.ratio;
                st_d.err    = 1'b0;
            end else begin
                st_d.cand    = cls_i.ratio;
                st_d.cand_ok = 1'b1;
                st_d.locked  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) st_q <= ST_IDLE;
        else            st_q <= st_d;
    end

    assign st_o = st_q;
endmodule

// File: rtl/sysclk_ratio_det.sv
module sysclk_ratio_det
    import sysclk_ratio_pkg::*;
#(
    parameter int unsigned BASE = 128,
    parameter int unsigned TOL  = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ws_in,
    input  logic       master_mode,
    output logic [1:0] ratio_code,
    output logic       locked,
    output logic       ratio_err
);
    localparam int unsigned CNT_W = period_width(BASE, TOL);

    logic             ws_rise;
    logic             period_evt;
    logic [CNT_W-1:0] period;
    class_t           cls;
    lock_st_t         st;

    sr_ws_sync u_sync (
        .clk    (clk),
        .rst    (rst),
        .ws_i   (ws_in),
        .rise_o (ws_rise)
    );

    sr_period_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .clr      (master_mode),
        .rise_i   (ws_rise),
        .period_o (period),
        .event_o  (period_evt)
    );

    sr_classify #(.BASE(BASE), .TOL(TOL), .CNT_W(CNT_W)) u_cls (
        .period_i (period),
        .result_o (cls)
    );

    sr_lock_ctrl u_lock (
        .clk     (clk),
        .rst     (rst),
        .clr     (master_mode),
        .event_i (period_evt),
        .cls_i   (cls),
        .st_o    (st)
    );

    // Master mode forces the 256 ratio as locked
    assign ratio_code = master_mode ? 2'b00 : st.code;
    assign locked     = master_mode ? 1'b1  : st.locked;
    assign ratio_err  = master_mode ? 1'b0  : st.err;
endmodule

// File: rtl/sysclk_ratio_det_chk.sv
module sysclk_ratio_det_chk (
    input logic       clk,
    input logic       rst,
    input logic       master_mode,
    input logic       rise,
    input logic       evt,
    input logic [1:0] ratio_code,
    input logic       locked,
    input logic       ratio_err
);
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && !master_mode) |-> (!locked && !ratio_err));

    a_r5_err_excludes_lock: assert property (@(posedge clk) disable iff (rst)
        ratio_err |-> !locked);

    a_r3_lock_after_event: assert property (@(posedge clk) disable iff (rst)
        (!master_mode && $rose(locked)) |-> $past(evt));

    a_r9_hold_between_events: assert property (@(posedge clk) disable iff (rst)
        (!master_mode && !$past(master_mode) && !$past(evt))
            |-> ($stable(ratio_code) && $stable(locked) && $stable(ratio_err)));

    a_r8_master_steady: assert property (@(posedge clk) disable iff (rst)
        (master_mode && $past(master_mode))
            |-> ($stable(ratio_code) && $stable(locked) && $stable(ratio_err)));

    a_r9_event_needs_edge: assert property (@(posedge clk) disable iff (rst)
        evt |-> rise);
endmodule

bind sysclk_ratio_det sysclk_ratio_det_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .master_mode (master_mode),
    .rise        (ws_rise),
    .evt         (period_evt),
    .ratio_code  (ratio_code),
    .locked      (locked),
    .ratio_err   (ratio_err)
);

// File: tb/sysclk_ratio_det_tb.sv
module sysclk_ratio_det_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ws = 1'b0;
    logic       master = 1'b0;
    logic [1:0] code;
    logic       locked;
    logic       err;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    always #2 clk = ~clk;   // 250 MHz

    sysclk_ratio_det dut_i (
        .clk         (clk),
        .rst         (rst),
        .ws_in       (ws),
        .master_mode (master),
        .ratio_code  (code),
        .locked      (locked),
        .ratio_err   (err)
    );

    // ---------------- behavioural reference model ----------------
    int hist[$];
    int m_cnt, m_ref, m_code, m_cand, m_cand_ok, m_lock, m_err;
    int noms[4] = '{256, 384, 512, 768};

    function automatic int classify(int p);
        for (int k = 0; k < 4; k++)
            if (p >= noms[k] - 2 && p <= noms[k] + 2) return k;
        return -1;
    endfunction

    task automatic model_clear();
        m_cnt = 0; m_ref = 0; m_code = 0; m_cand = 0;
        m_cand_ok = 0; m_lock = 0; m_err = 0;
    endtask

    always @(posedge clk) begin
        int rise_now;
        int c;
        if (rst) begin
            hist = '{0, 0, 0};
            model_clear();
        end else begin
            rise_now = (hist[1] == 1 && hist[0] == 0) ? 1 : 0;
            if (master) begin
                model_clear();
            end else if (rise_now == 1) begin
                if (m_ref == 1) begin
                    c = classify(m_cnt);
                    if (c < 0) begin
                        m_lock = 0; m_err = 1; m_cand_ok = 0;
                    end else if (m_cand_ok == 1 && m_cand == c) begin
                        m_lock = 1; m_code = c; m_err = 0;
                    end else begin
                        m_cand = c; m_cand_ok = 1; m_lock = 0;
                    end
                end
                m_cnt = 1;
                m_ref = 1;
            end else if (m_cnt < 1023) begin
                m_cnt++;
            end
            hist.push_back(int'(ws));
            void'(hist.pop_front());
        end
    end

    // Compare against the model on every clock, away from the edge
    always @(posedge clk) begin
        int e_code, e_lock, e_err;
        #1;
        if (!done) begin
            e_code = master ? 0 : m_code;
            e_lock = master ? 1 : m_lock;
            e_err  = master ? 0 : m_err;
            checks++;
            if (int'(code) != e_code || int'(locked) != e_lock || int'(err) != e_err) begin
                errors++;
                $display("FAIL %s model: code=%0d locked=%0d err=%0d exp code=%0d locked=%0d err=%0d @%0t",
                         cur_req, code, locked, err, e_code, e_lock, e_err, $time);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic gen_period(int p, int n);
        for (int j = 0; j < n; j++)
            for (int i = 0; i < p; i++) begin
                @(negedge clk);
                ws = (i < p / 2);
            end
    endtask

    task automatic dir_check(string req, int c_e, int l_e, int e_e);
        checks++;
        if (int'(code) != c_e || int'(locked) != l_e || int'(err) != e_e) begin
            errors++;
            $display("FAIL %s directed: code=%0d locked=%0d err=%0d exp code=%0d locked=%0d err=%0d",
                     req, code, locked, err, c_e, l_e, e_e);
        end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finished");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // ---------------- directed sequence ----------------
    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        dir_check("R1", 0, 0, 0);

        cur_req = "R3";
        gen_period(384, 2);
        dir_check("R3", 0, 0, 0);          // reference + one period: no lock yet
        gen_period(384, 1);
        dir_check("R2", 1, 1, 0);          // 384 -> code 01

        cur_req = "R6";
        gen_period(512, 2);
        dir_check("R6", 1, 0, 0);          // ratio change: unlocked, no error
        gen_period(512, 1);
        dir_check("R6", 2, 1, 0);          // 512 -> code 10

        cur_req = "R4";
        gen_period(770, 3);
        dir_check("R4", 3, 1, 0);          // +2 edge of 768 window
        gen_period(766, 2);
        dir_check("R4", 3, 1, 0);          // -2 edge of 768 window

        cur_req = "R5";
        gen_period(259, 2);
        dir_check("R5", 3, 0, 1);          // +3 off 256: mismatch, code held

        cur_req = "R7";
        gen_period(256, 2);
        dir_check("R7", 3, 0, 1);          // candidate only, error kept
        gen_period(256, 1);
        dir_check("R7", 0, 1, 0);          // lock clears error

        cur_req = "R4";
        gen_period(253, 2);
        dir_check("R4", 0, 0, 1);          // -3 off 256: mismatch
        gen_period(254, 3);
        dir_check("R4", 0, 1, 0);          // -2 off 256: matches

        cur_req = "R10";
        gen_period(1408, 1);
        gen_period(256, 1);
        dir_check("R10", 0, 0, 1);         // saturated count is a mismatch
        gen_period(256, 2);
        dir_check("R10", 0, 1, 0);

        cur_req = "R8";
        master = 1'b1;
        gen_period(512, 3);
        dir_check("R8", 0, 1, 0);          // forced 256, locked
        master = 1'b0;
        gen_period(512, 2);
        dir_check("R8", 0, 0, 0);          // restart needs reference edge
        gen_period(512, 1);
        dir_check("R8", 2, 1, 0);

        cur_req = "R9";
        repeat (100) begin
            @(negedge clk);
            ws = 1'b0;
        end
        @(negedge clk);
        ws = 1'b1;                         // period of 612: mismatch
        @(negedge clk);
        dir_check("R9", 2, 1, 0);          // one edge: no change
        @(negedge clk);
        dir_check("R9", 2, 1, 0);          // two edges: no change
        @(negedge clk);
        dir_check("R9", 2, 0, 1);          // third edge: update
        @(negedge clk);
        ws = 1'b0;
        repeat (8) @(negedge clk);

        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule